// File: doc/BRIEF.md
# Subsystem Reset Release Sequencer

This block owns a vector of active-low device reset lines and takes the devices out of reset in a fixed, clock-aware order. A one-cycle start pulse puts every device back into reset. From there the memory subsystem comes out of reset first. Its core reset is released once the memory clock reports ready. The bus-interface and PHY resets follow together, but only after at least one memory-controller clock has passed. A quiet period of 256 memory-controller clocks must then elapse before memory is reported usable. Only after that are the network and chip-to-chip link resets released, each waiting for its own clock-ready input.

The memory-controller clock is seen through `mem_tick_i`, which pulses once per memory-controller cycle in this block's clock domain. The link reset is part of the sequence only when the peripheral clock source is absent. That condition is sampled at the start pulse. The PCIe auxiliary reset is never released by this sequence.

Top module: `rst_release_seq`

## Requirements
- R1: `rst_vec_o` bit positions are 0 memory core, 1 memory AXI, 2 memory AHB, 3 memory PHY, 4 PCIe auxiliary, 5 Ethernet, 6 link; a 1 means released. After reset all outputs are 0.
- R2: A start pulse clears the whole vector and `mem_ready_o` on the next edge, even in mid-sequence, and restarts the sequence; it also samples `pclk_present_i`.
- R3: Bit 0 is set on the first edge after start at which `mem_clk_ready_i` is sampled high; no other bit is set before it.
- R4: Bits 1, 2 and 3 are set together on the edge that samples the first `mem_tick_i` after the edge that set bit 0.
- R5: `mem_ready_o` rises on the edge that samples the 256th `mem_tick_i` counted after the edge that set bits 1 to 3.
- R6: Bit 5 is set on the first edge at which `mem_ready_o` is already high and `eth_clk_ready_i` is high.
- R7: Bit 6 is set under the same rule with `link_clk_ready_i`, but only if `pclk_present_i` was low at the start pulse; otherwise it stays 0.
- R8: Bit 4 stays 0 at all times.
- R9: `busy_o` is high from the edge after start until memory is ready and every enabled late reset (Ethernet, plus link when enabled) is released; it falls in the same cycle as the last release.
- R10: A released bit stays 1 until the next start or reset, whatever the ready inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins (or restarts) the sequence |
| mem_clk_ready_i | input | 1 | Memory clock locked and ungated |
| mem_tick_i | input | 1 | One pulse per memory-controller clock cycle |
| eth_clk_ready_i | input | 1 | Ethernet clock locked and ungated |
| link_clk_ready_i | input | 1 | Link clock ready |
| pclk_present_i | input | 1 | Peripheral clock source present (disables the link step) |
| rst_vec_o | output | 7 | Active-low reset lines, 1 = out of reset |
| mem_ready_o | output | 1 | Memory subsystem may be accessed |
| busy_o | output | 1 | Sequence in progress |

## Verification
The start pulse, the core release, the side release and the memory-ready rise each appear one edge after the input that causes them is sampled. The late releases appear one edge after `mem_ready_o` is already high with their clock ready. `busy_o` is combinational on those registers and falls in the same cycle as the last release. A behavioural model in the bench applies these per-edge rules to the same inputs and is compared with the outputs at every falling edge, where all registered values are settled. Directed checks at chosen points cover holding in reset without a clock, the gap with no tick, restart during the quiet count, the link being disabled and enabled, and released bits holding after the ready inputs drop.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int NUM_RST = 7;
  localparam int RB_CORE = 0;
  localparam int RB_AXI  = 1;
  localparam int RB_AHB  = 2;
  localparam int RB_PHY  = 3;
  localparam int RB_PCIE = 4;
  localparam int RB_ETH  = 5;
  localparam int RB_LINK = 6;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_WAIT_CLK,
    MS_GAP,
    MS_QUIET,
    MS_DONE
  } mem_state_e;
endpackage

// File: rtl/rrs_mem_stage.sv
module rrs_mem_stage
  import rrs_pkg::*;
#(
  parameter int QUIET_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clk_ready_i,
  input  logic tick_i,
  output logic core_rel_o,
  output logic side_rel_o,
  output logic ready_o
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUIET_CYCLES - 1);

  mem_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic core_q, core_d, side_q, side_d, ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    core_d  = core_q;
    side_d  = side_q;
    ready_d = ready_q;
    if (start_i) begin
      state_d = MS_WAIT_CLK;
      cnt_d   = '0;
      core_d  = 1'b0;
      side_d  = 1'b0;
      ready_d = 1'b0;
    end else begin
      case (state_q)
        MS_WAIT_CLK: if (clk_ready_i) begin
          core_d  = 1'b1;
          state_d = MS_GAP;
        end
        MS_GAP: if (tick_i) begin
          side_d  = 1'b1;
          cnt_d   = '0;
          state_d = MS_QUIET;
        end
        MS_QUIET: if (tick_i) begin
          if (cnt_q == LAST) begin
            ready_d = 1'b1;
            state_d = MS_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      core_q  <= 1'b0;
      side_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      core_q  <= core_d;
      side_q  <= side_d;
      ready_q <= ready_d;
    end
  end

  assign core_rel_o = core_q;
  assign side_rel_o = side_q;
  assign ready_o    = ready_q;
endmodule

// File: rtl/rrs_late_stage.sv
module rrs_late_stage #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mem_ready_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] clk_ready_i,
  output logic [NUM_CH-1:0] rel_o,
  output logic              done_o
);
  logic [NUM_CH-1:0] en_q, rel_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic en_d, rel_d;

    always_comb begin
      en_d  = en_q[i];
      rel_d = rel_q[i];
      if (start_i) begin
        en_d  = en_i[i];
        rel_d = 1'b0;
      end else if (en_q[i] && mem_ready_i && clk_ready_i[i]) begin
        rel_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]  <= 1'b0;
        rel_q[i] <= 1'b0;
      end else begin
        en_q[i]  <= en_d;
        rel_q[i] <= rel_d;
      end
    end
  end

  assign rel_o  = rel_q;
  assign done_o = &(rel_q | ~en_q);
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rrs_pkg::*;
#(
  parameter int QUIET_CYCLES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               mem_clk_ready_i,
  input  logic               mem_tick_i,
  input  logic               eth_clk_ready_i,
  input  logic               link_clk_ready_i,
  input  logic               pclk_present_i,
  output logic [NUM_RST-1:0] rst_vec_o,
  output logic               mem_ready_o,
  output logic               busy_o
);
  localparam int NUM_LATE = 2;

  logic core_rel, side_rel, mem_ready, late_done, all_done;
  logic [NUM_LATE-1:0] late_en, late_clk_ready, late_rel;
  logic active_q, active_d;

  rrs_mem_stage #(.QUIET_CYCLES(QUIET_CYCLES)) u_mem (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .clk_ready_i (mem_clk_ready_i),
    .tick_i      (mem_tick_i),
    .core_rel_o  (core_rel),
    .side_rel_o  (side_rel),
    .ready_o     (mem_ready)
  );

  assign late_en        = {~pclk_present_i, 1'b1};
  assign late_clk_ready = {link_clk_ready_i, eth_clk_ready_i};

  rrs_late_stage #(.NUM_CH(NUM_LATE)) u_late (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_ready_i (mem_ready),
    .en_i        (late_en),
    .clk_ready_i (late_clk_ready),
    .rel_o       (late_rel),
    .done_o      (late_done)
  );

  assign all_done = mem_ready && late_done;

  always_comb begin
    active_d = active_q;
    if (start_i)       active_d = 1'b1;
    else if (all_done) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_comb begin
    rst_vec_o          = '0;
    rst_vec_o[RB_CORE] = core_rel;
    rst_vec_o[RB_AXI]  = side_rel;
    rst_vec_o[RB_AHB]  = side_rel;
    rst_vec_o[RB_PHY]  = side_rel;
    rst_vec_o[RB_PCIE] = 1'b0;
    rst_vec_o[RB_ETH]  = late_rel[0];
    rst_vec_o[RB_LINK] = late_rel[1];
  end

  assign mem_ready_o = mem_ready;
  assign busy_o      = active_q && !all_done;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       mem_clk_ready_i,
  input logic       eth_clk_ready_i,
  input logic       link_clk_ready_i,
  input logic [6:0] rst_vec_o,
  input logic       mem_ready_o,
  input logic       busy_o
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (rst_vec_o == 7'h00) && !mem_ready_o && busy_o);

  p_core_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_vec_o != 7'h00) |-> rst_vec_o[0]);

  p_core_needs_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_vec_o[0]) |-> $past(mem_clk_ready_i));

  p_side_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rst_vec_o[3:1]) == 0) || ($countones(rst_vec_o[3:1]) == 3));

  p_side_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_vec_o[1]) |-> $past(rst_vec_o[0]));

  p_ready_memory_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready_o |-> (rst_vec_o[3:0] == 4'hF));

  p_eth_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_vec_o[5]) |-> $past(mem_ready_o) && $past(eth_clk_ready_i));

  p_link_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_vec_o[6]) |-> $past(mem_ready_o) && $past(link_clk_ready_i));

  p_pcie_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_vec_o[4]);

  p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> mem_ready_o && rst_vec_o[5]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && rst_vec_o[5]) |=> rst_vec_o[5]);
endmodule

bind rst_release_seq rrs_checker chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .start_i          (start_i),
  .mem_clk_ready_i  (mem_clk_ready_i),
  .eth_clk_ready_i  (eth_clk_ready_i),
  .link_clk_ready_i (link_clk_ready_i),
  .rst_vec_o        (rst_vec_o),
  .mem_ready_o      (mem_ready_o),
  .busy_o           (busy_o)
);

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mclk_rdy = 1'b0, tick = 1'b0, eth_rdy = 1'b0;
  logic link_rdy = 1'b0, pclk = 1'b1;
  logic [6:0] vec;
  logic mready, busy;

  int tests = 0, fails = 0;
  int tick_div = 0, tick_cnt = 0;

  // reference model state
  int ph = 0, qt = 0;
  logic [6:0] m_vec = '0;
  logic m_rdy = 1'b0, m_act = 1'b0, m_link_en = 1'b0;

  always #2 clk = ~clk;

  rst_release_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mem_clk_ready_i(mclk_rdy),
    .mem_tick_i(tick), .eth_clk_ready_i(eth_rdy), .link_clk_ready_i(link_rdy),
    .pclk_present_i(pclk), .rst_vec_o(vec), .mem_ready_o(mready), .busy_o(busy)
  );

  function automatic logic m_done();
    return m_rdy && m_vec[5] && (m_vec[6] || !m_link_en);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; qt = 0; m_vec = '0; m_rdy = 0; m_act = 0; m_link_en = 0;
    end else if (start) begin
      ph = 1; qt = 0; m_vec = '0; m_rdy = 0; m_act = 1; m_link_en = !pclk;
    end else begin
      logic old_rdy, fin;
      old_rdy = m_rdy;
      fin = m_done();
      if (m_act && fin) m_act = 0;
      if (old_rdy && eth_rdy) m_vec[5] = 1;
      if (old_rdy && m_link_en && link_rdy) m_vec[6] = 1;
      if (ph == 1 && mclk_rdy) begin m_vec[0] = 1; ph = 2; end
      else if (ph == 2 && tick) begin m_vec[3:1] = 3'b111; ph = 3; qt = 0; end
      else if (ph == 3 && tick) begin
        qt++;
        if (qt == 256) begin m_rdy = 1; ph = 4; end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 vector", 32'(vec), 32'(m_vec));
      check("R5 mem_ready", 32'(mready), 32'(m_rdy));
      check("R9 busy", 32'(busy), 32'(m_act && !m_done()));
    end
  end

  // memory-controller tick generator
  always @(negedge clk) begin
    if (tick_div == 0) begin
      tick <= 1'b0; tick_cnt <= 0;
    end else if (tick_cnt >= tick_div - 1) begin
      tick <= 1'b1; tick_cnt <= 0;
    end else begin
      tick <= 1'b0; tick_cnt <= tick_cnt + 1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000 && !mready; i++) step(1);
    check("R5 ready reached", 32'(mready), 32'd1);
  endtask

  initial begin
    step(3);
    check("R1 reset vector", 32'(vec), 32'h0);
    check("R9 reset busy", 32'(busy), 32'h0);
    rst_n = 1'b1;
    step(2);

    // Scenario A: peripheral clock present, slow ticks
    pclk = 1'b1;
    pulse_start();
    check("R2 start clears", 32'(vec), 32'h0);
    check("R9 busy after start", 32'(busy), 32'h1);
    step(5);
    check("R3 held without clock", 32'(vec), 32'h0);
    mclk_rdy = 1'b1;
    step(3);
    check("R3 core only", 32'(vec), 32'h01);
    eth_rdy = 1'b1;
    step(2);
    check("R4 gap waits for tick", 32'(vec[3:1]), 32'h0);
    check("R6 eth waits for memory", 32'(vec[5]), 32'h0);
    tick_div = 3;
    wait_ready();
    check("R5 memory bits", 32'(vec[3:0]), 32'hF);
    step(2);
    check("R6 eth released", 32'(vec[5]), 32'h1);
    check("R7 link disabled", 32'(vec[6]), 32'h0);
    check("R8 pcie held", 32'(vec[4]), 32'h0);
    check("R9 busy done", 32'(busy), 32'h0);

    // Scenario B: link enabled, restart mid-count
    pclk = 1'b0; tick_div = 1;
    pulse_start();
    check("R2 restart clears", 32'(vec), 32'h0);
    check("R2 ready cleared", 32'(mready), 32'h0);
    step(40);
    pulse_start();
    check("R2 mid-count restart", 32'(vec), 32'h0);
    pclk = 1'b1;
    wait_ready();
    step(3);
    check("R6 eth again", 32'(vec[5]), 32'h1);
    check("R7 link waits for clock", 32'(vec[6]), 32'h0);
    check("R9 busy while link pending", 32'(busy), 32'h1);
    link_rdy = 1'b1;
    step(2);
    check("R7 link released", 32'(vec[6]), 32'h1);
    check("R9 busy cleared", 32'(busy), 32'h0);
    mclk_rdy = 1'b0; eth_rdy = 1'b0; link_rdy = 1'b0; tick_div = 0;
    step(10);
    check("R10 bits sticky", 32'(vec), 32'h6F);
    check("R8 pcie still held", 32'(vec[4]), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule